// File: doc/BRIEF.md
# High-Rate Sample Interleaver

This block turns a stream of captured input samples into 16-bit memory events. The event format depends on the capture rate. In the wide mode, each event is one 16-channel sample. In the double-rate mode, two consecutive samples of 8 channels are merged into one event. In the quad-rate mode, four consecutive samples of 4 channels are merged into one event. The bits are merged by interleaving them, not by placing the samples end to end. The samples that share one event therefore sit next to each other, bit by bit, for every channel.

Both sides of the block use a valid/ready handshake. A sample transfers on a rising clock edge where `smp_valid` and `smp_ready` are both high. An event transfers on an edge where `evt_valid` and `evt_ready` are both high. The block holds one finished event. While that event is stalled, `smp_ready` is low, so no sample can be lost. The sink may hold `evt_ready` low for any number of cycles. The rate mode is a plain control input. If it changes, any gather that is only partly filled is thrown away.

Top module: `sample_interleaver`

## Requirements
- R1: After reset, `evt_valid` is 0 and `smp_ready` is 1.
- R2: With `rate_mode` = 0, each accepted sample produces one event equal to the whole 16-bit sample.
- R3: With `rate_mode` = 1, two accepted samples make one event. Event bit 2c+t holds bit c of sample t, for c in 0..7, where t = 0 is the older sample. Sample bits 15:8 are ignored.
- R4: With `rate_mode` = 2, four accepted samples make one event. Event bit 4c+t holds bit c of sample t, for c in 0..3, where t = 0 is the oldest sample. Sample bits 15:4 are ignored.
- R5: Exactly one event is produced for every N accepted samples, where N is 1, 2 or 4 for the active mode. No event is produced from fewer samples.
- R6: When `rate_mode` differs from its value in the previous cycle, the partial gather is dropped. A sample accepted in that cycle is the first sample of a new event in the new mode.
- R7: While `evt_valid` is 1 and `evt_ready` is 0, `evt_valid` stays 1 and `evt_data` does not change.
- R8: `smp_ready` is 1 exactly when no event is held or the held event is being taken in the same cycle.
- R9: `rate_mode` = 3 behaves like `rate_mode` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rate_mode | input | 2 | Rate mode: 0 wide, 1 double-rate, 2 quad-rate, 3 same as 0 |
| smp_valid | input | 1 | Input sample valid |
| smp_ready | output | 1 | Block can accept a sample this cycle |
| smp_data | input | 16 | Input sample, one bit per channel |
| evt_valid | output | 1 | Event valid |
| evt_ready | input | 1 | Sink accepts the event |
| evt_data | output | 16 | Interleaved event word |

## Verification
Most wrong internal states in this block show up at the next event boundary. A gather counter that is off by one makes the event come out after the wrong number of samples. A wrong counter also moves every bit into the wrong time slot, which the very next compared event exposes. A gather that is not flushed on a mode change gives a first event mixed from the old and new modes. A broken output hold corrupts the data in the first stalled cycle. If the ready signal is wrong, either a sample is dropped, which shifts all later events, or an event is lost, which leaves the expected queue unbalanced when the run drains.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  typedef enum logic [1:0] {
    MODE_WIDE = 2'd0,
    MODE_X2   = 2'd1,
    MODE_X4   = 2'd2,
    MODE_ALT  = 2'd3
  } rate_mode_e;

  // number of samples folded into one event
  function automatic logic [2:0] slots_of(rate_mode_e m);
    case (m)
      MODE_X2: return 3'd2;
      MODE_X4: return 3'd4;
      default: return 3'd1;
    endcase
  endfunction

  // log2 of the slot count, selects the interleave variant
  function automatic logic [1:0] group_of(rate_mode_e m);
    case (m)
      MODE_X2: return 2'd1;
      MODE_X4: return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/ilv_gather.sv
module ilv_gather
  import ilv_pkg::*;
#(
  parameter int EVT_W = 16,
  parameter int MAX_N = 4,
  localparam int CW = $clog2(MAX_N),
  localparam int NW = CW + 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  rate_mode_e                        mode,
  input  logic                              acc,
  input  logic [EVT_W-1:0]                  sample,
  output logic [MAX_N-2:0][EVT_W-1:0]       hist,
  output logic                              done
);

  rate_mode_e      mode_q;
  logic [CW-1:0]   cnt;
  logic [CW-1:0]   eff_cnt;
  logic            flush;
  logic [NW-1:0]   n_cur;

  assign flush   = (mode != mode_q);
  assign eff_cnt = flush ? '0 : cnt;
  assign n_cur   = NW'(slots_of(mode));
  assign done    = acc && ({1'b0, eff_cnt} == n_cur - NW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_WIDE;
      cnt    <= '0;
      hist   <= '0;
    end else begin
      mode_q <= mode;
      if (acc) begin
        if (done) begin
          cnt <= '0;
        end else begin
          if (eff_cnt < CW'(MAX_N - 1)) hist[eff_cnt] <= sample;
          cnt <= eff_cnt + CW'(1);
        end
      end else if (flush) begin
        cnt <= '0;
      end
    end
  end

  // R6: a mode change with no sample in that cycle leaves an empty gather
  a_r6_flush_on_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !acc) |=> (cnt == '0));

  // R5: the fill level never reaches the slot count of the active mode
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, cnt} < NW'(slots_of(mode_q))));

endmodule

// File: rtl/ilv_pack.sv
module ilv_pack
  import ilv_pkg::*;
#(
  parameter int EVT_W = 16,
  parameter int MAX_N = 4,
  localparam int NG = $clog2(MAX_N) + 1
) (
  input  rate_mode_e                   mode,
  input  logic [MAX_N-2:0][EVT_W-1:0]  hist,
  input  logic [EVT_W-1:0]             cur,
  output logic [EVT_W-1:0]             evt
);

  logic [NG-1:0][EVT_W-1:0] variant;
  logic                     unused_hist;

  assign unused_hist = ^hist;

  for (genvar g = 0; g < NG; g++) begin : g_var
    localparam int N = 1 << g;
    for (genvar c = 0; c < EVT_W / N; c++) begin : g_ch
      for (genvar t = 0; t < N; t++) begin : g_slot
        if (t == N - 1) begin : g_new
          assign variant[g][c*N + t] = cur[c];
        end else begin : g_old
          assign variant[g][c*N + t] = hist[t][c];
        end
      end
    end
  end

  always_comb begin
    evt = variant[0];
    for (int g = 0; g < NG; g++) begin
      if (int'(group_of(mode)) == g) evt = variant[g];
    end
  end

endmodule

// File: rtl/ilv_outreg.sv
module ilv_outreg #(
  parameter int EVT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [EVT_W-1:0] din,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [EVT_W-1:0] out_data,
  output logic             take_ok
);

  assign take_ok = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= din;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R7: a stalled event stays put
  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R8: a new event only lands in a free or draining slot
  a_r8_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (!out_valid || out_ready));

endmodule

// File: rtl/sample_interleaver.sv
module sample_interleaver
  import ilv_pkg::*;
#(
  parameter int EVT_W = 16,
  parameter int MAX_N = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       rate_mode,
  input  logic             smp_valid,
  output logic             smp_ready,
  input  logic [EVT_W-1:0] smp_data,
  output logic             evt_valid,
  input  logic             evt_ready,
  output logic [EVT_W-1:0] evt_data
);

  rate_mode_e                    mode;
  logic                          acc;
  logic                          done;
  logic [MAX_N-2:0][EVT_W-1:0]   hist;
  logic [EVT_W-1:0]              packed_evt;

  assign mode = rate_mode_e'(rate_mode);
  assign acc  = smp_valid && smp_ready;

  ilv_gather #(.EVT_W(EVT_W), .MAX_N(MAX_N)) u_gather (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode   (mode),
    .acc    (acc),
    .sample (smp_data),
    .hist   (hist),
    .done   (done)
  );

  ilv_pack #(.EVT_W(EVT_W), .MAX_N(MAX_N)) u_pack (
    .mode (mode),
    .hist (hist),
    .cur  (smp_data),
    .evt  (packed_evt)
  );

  ilv_outreg #(.EVT_W(EVT_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (done),
    .din       (packed_evt),
    .out_ready (evt_ready),
    .out_valid (evt_valid),
    .out_data  (evt_data),
    .take_ok   (smp_ready)
  );

  // R2/R9: in the single-slot modes every accepted sample yields an event
  a_r2_single_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && slots_of(mode) == 3'd1) |=> evt_valid);

endmodule

// File: tb/sample_interleaver_tb.sv
module sample_interleaver_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  rate_mode = 2'd0;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [15:0] smp_data = '0;
  logic        evt_valid;
  logic        evt_ready = 1'b1;
  logic [15:0] evt_data;

  int n_tests = 0;
  int n_fail  = 0;
  int seen    = 0;
  int pushed  = 0;
  bit bp_on   = 1'b0;
  bit mon_on  = 1'b0;

  logic [15:0] exp_q[$];
  int          tag_q[$];
  logic [15:0] mbuf[4];
  int          mcnt = 0;

  always #5 clk = ~clk;

  sample_interleaver u_dut (
    .clk(clk), .rst_n(rst_n), .rate_mode(rate_mode),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_data(evt_data)
  );

  function automatic int n_of(logic [1:0] m);
    return (m == 2'd1) ? 2 : (m == 2'd2) ? 4 : 1;
  endfunction

  function automatic string tag_of(int m);
    case (m)
      1: return "R3";
      2: return "R4";
      3: return "R9";
      default: return "R2";
    endcase
  endfunction

  task automatic check(bit ok, string req, logic [15:0] act, logic [15:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_mode(logic [1:0] m);
    rate_mode = m;
    mcnt = 0;  // R6: partial gather discarded
  endtask

  // driver: sends one sample, updates the reference gather
  task automatic send(logic [15:0] s);
    bit ok;
    int n;
    logic [15:0] e;
    smp_valid = 1'b1;
    smp_data  = s;
    forever begin
      #2 ok = smp_ready;
      @(posedge clk);
      if (ok) break;
      @(negedge clk);
    end
    @(negedge clk);
    smp_valid = 1'b0;
    n = n_of(rate_mode);
    mbuf[mcnt] = s;
    mcnt++;
    if (mcnt == n) begin
      e = '0;
      for (int c = 0; c < 16 / n; c++)
        for (int t = 0; t < n; t++)
          e[c*n + t] = mbuf[t][c];
      exp_q.push_back(e);
      tag_q.push_back(int'(rate_mode));
      pushed++;
      mcnt = 0;
    end
  endtask

  // monitor: drives ready and compares events as they leave
  initial begin
    int cyc = 0;
    bit held = 1'b0;
    logic [15:0] held_d = '0;
    wait (mon_on);
    forever begin
      @(negedge clk);
      cyc++;
      evt_ready = bp_on ? (cyc % 3 == 0) : 1'b1;
      #1;
      if (held) begin
        check(evt_valid && evt_data == held_d, "R7", evt_data, held_d);
        held = 1'b0;
      end
      if (evt_valid && evt_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R5", evt_data, 16'h0000);
        end else begin
          logic [15:0] e;
          int m;
          e = exp_q.pop_front();
          m = tag_q.pop_front();
          check(evt_data == e, tag_of(m), evt_data, e);
          seen++;
        end
      end else if (evt_valid) begin
        held = 1'b1;
        held_d = evt_data;
        check(smp_ready == 1'b0, "R8", {15'd0, smp_ready}, 16'h0000);
      end else begin
        check(smp_ready == 1'b1, "R8", {15'd0, smp_ready}, 16'h0001);
      end
    end
  end

  initial begin
    #1_000_000;
    n_fail++;
    n_tests++;
    $display("FAIL watchdog R5 actual=%0d expected=%0d", seen, pushed);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic drain();
    for (int i = 0; i < 60 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(evt_valid == 1'b0, "R1", {15'd0, evt_valid}, 16'h0000);
    check(smp_ready == 1'b1, "R1", {15'd0, smp_ready}, 16'h0001);
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1'b1;

    // R2 wide mode
    set_mode(2'd0);
    for (int i = 0; i < 6; i++) send(16'h1357 * (i + 3) ^ 16'hA5C3);
    // R3 double rate, upper bits garbage
    set_mode(2'd1);
    for (int i = 0; i < 8; i++) send(16'hF0F0 ^ (16'h2B1D * (i + 1)));
    // R4 quad rate
    set_mode(2'd2);
    send(16'hFFF1); send(16'h0002); send(16'hABC4); send(16'h5558);
    for (int i = 0; i < 8; i++) send(16'h9E37 * (i + 7));
    // R9 alternate wide code
    set_mode(2'd3);
    for (int i = 0; i < 4; i++) send(16'h7E81 + 16'(i * 311));
    drain();

    // R6 mode change drops partial gathers
    set_mode(2'd2);
    send(16'hFFFF); send(16'hFFFF);
    set_mode(2'd1);
    send(16'h0012); send(16'h0034);
    send(16'h00FF);
    set_mode(2'd0);
    send(16'hC0DE);
    drain();
    check(seen == pushed, "R6", 16'(seen), 16'(pushed));

    // R7/R8 with back-pressure
    bp_on = 1'b1;
    set_mode(2'd0);
    for (int i = 0; i < 6; i++) send(16'h4D2B + 16'(i * 977));
    set_mode(2'd2);
    for (int i = 0; i < 16; i++) send(16'h3C5A ^ 16'(i * 4099));
    drain();
    bp_on = 1'b0;
    drain();

    check(exp_q.size() == 0, "R5", 16'(exp_q.size()), 16'h0000);
    check(seen == pushed, "R5", 16'(seen), 16'(pushed));
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule